// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display link. A horizontal position counter and a line counter step through each frame, and the block drives horizontal blank, horizontal sync, vertical blank, vertical sync and a data-enable strobe. It also reports the current pixel and line coordinates. Each enabled clock moves the horizontal position forward by a fixed number of pixels handled in parallel (1, 2 or 4, chosen at elaboration). Every line and every frame opens with its blanking interval, and active video follows.

All timing values are set at run time. A single-cycle load strobe captures the configuration inputs into a pending set. The pending set becomes the active set only when the counters wrap to the first position of a new frame, so a frame never mixes old and new timing. Vertical sync does not switch at line start: it turns on and off at programmable horizontal positions on its first and last lines. Each of the four timing outputs has its own polarity bit.

Top module: `raster_timing_gen`

## Requirements
- R1: Vertical blank is asserted on lines 0 up to, but not including, the vertical-blank-end line. The total lines per frame is a separate programmed value.
- R2: On each enabled clock the horizontal position grows by the parallel pixel count. When the result reaches or passes the line total, the position goes to 0 and the line increments. The line wraps to 0 when it reaches the frame line total.
- R3: Vertical sync is asserted from (sync-on line, sync-on horizontal position) up to, but not including, (sync-off line, sync-off horizontal position), comparing line first and position second.
- R4: Horizontal blank is asserted for positions 0 up to, but not including, the horizontal-blank-end position.
- R5: Horizontal sync is asserted for positions from the sync-on position up to, but not including, the sync-off position.
- R6: Polarity bit 0 inverts horizontal blank, bit 1 inverts horizontal sync, bit 2 inverts vertical blank and bit 3 inverts vertical sync. When a bit is 1 its output is active low.
- R7: Data-enable is active high and is asserted exactly when the position is outside both blanking regions. It does not depend on the polarity bits.
- R8: A load strobe captures the configuration inputs at the clock edge where it is sampled. The captured set takes effect only at a later edge where the counters wrap to line 0, position 0. A later load before that wrap replaces the pending set.
- R9: A low synchronous reset sets position 0, line 0 and the parameter default timing for both the active and the pending set. The outputs then show the decode of that position.
- R10: When the advance enable is low, the position, the line and every timing output hold their values. A load made in that time changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Advance the raster by one clock's worth of pixels |
| cfg_load | input | 1 | Capture the configuration inputs into the pending set |
| cfg_htotal | input | 12 | Pixels per line |
| cfg_hblank_end | input | 12 | First active pixel position |
| cfg_hsync_on | input | 12 | Horizontal sync first position |
| cfg_hsync_off | input | 12 | Horizontal sync end position (exclusive) |
| cfg_vsync_hon | input | 12 | Horizontal position where vertical sync starts |
| cfg_vsync_hoff | input | 12 | Horizontal position where vertical sync ends |
| cfg_vtotal | input | 11 | Lines per frame |
| cfg_vblank_end | input | 11 | First active line |
| cfg_vsync_on | input | 11 | Vertical sync first line |
| cfg_vsync_off | input | 11 | Vertical sync last line (ends at its horizontal end position) |
| cfg_polarity | input | 4 | Polarity bits per R6 |
| hblank_o | output | 1 | Horizontal blank |
| hsync_o | output | 1 | Horizontal sync |
| vblank_o | output | 1 | Vertical blank |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 12 | Current horizontal position in pixels |
| line_y_o | output | 11 | Current line |

## Verification
Every output comes from a register that updates at the same edge as the counters. After an enabled edge, the new coordinates and the decode of that new position can be read together one edge later, with no further pipeline delay. A load affects nothing on the edge that samples it. Its values first show after the next frame wrap edge, and a reset shows at the first edge where it is sampled low. The bench keeps a behavioural model that it updates at each rising edge from the inputs it drove, and compares all seven outputs against that model at the following falling edge.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int unsigned HW = 12;
    localparam int unsigned VW = 11;

    localparam int unsigned POL_HB = 0;
    localparam int unsigned POL_HS = 1;
    localparam int unsigned POL_VB = 2;
    localparam int unsigned POL_VS = 3;

    typedef logic [HW-1:0] hpos_t;
    typedef logic [VW-1:0] vpos_t;

    typedef struct packed {
        hpos_t      htotal;
        hpos_t      hbend;
        hpos_t      hs_on;
        hpos_t      hs_off;
        hpos_t      vs_hon;
        hpos_t      vs_hoff;
        vpos_t      vtotal;
        vpos_t      vbend;
        vpos_t      vs_von;
        vpos_t      vs_voff;
        logic [3:0] pol;
    } timing_t;

    typedef struct packed {
        logic hblank;
        logic hsync;
        logic vblank;
        logic vsync;
        logic de;
    } flags_t;

    // Decode of one raster position under one timing set (R1, R3-R7).
    function automatic flags_t decode_flags(hpos_t h, vpos_t v, timing_t t);
        flags_t          f;
        logic            hb;
        logic            vb;
        logic            hs;
        logic            vs;
        logic [HW+VW-1:0] pos;
        logic [HW+VW-1:0] von;
        logic [HW+VW-1:0] voff;
        hb   = (h < t.hbend);
        vb   = (v < t.vbend);
        hs   = (h >= t.hs_on) && (h < t.hs_off);
        pos  = {v, h};
        von  = {t.vs_von, t.vs_hon};
        voff = {t.vs_voff, t.vs_hoff};
        vs   = (pos >= von) && (pos < voff);
        f.hblank = hb ^ t.pol[POL_HB];
        f.hsync  = hs ^ t.pol[POL_HS];
        f.vblank = vb ^ t.pol[POL_VB];
        f.vsync  = vs ^ t.pol[POL_VS];
        f.de     = !hb && !vb;
        return f;
    endfunction

endpackage

// File: rtl/raster_step.sv
module raster_step
    import raster_pkg::*;
#(
    parameter int unsigned PPC = 2
) (
    input  hpos_t h_q,
    input  vpos_t v_q,
    input  hpos_t htotal,
    input  vpos_t vtotal,
    input  logic  adv,
    output hpos_t h_d,
    output vpos_t v_d,
    output logic  frame_wrap
);

    localparam int unsigned LSB = $clog2(PPC);

    logic [HW:0] h_inc;
    logic [HW:0] h_aligned;
    logic [VW:0] v_inc;

    assign h_inc = {1'b0, h_q} + (HW+1)'(PPC);
    assign v_inc = {1'b0, v_q} + (VW+1)'(1);

    // With several pixels per clock the low position bits stay zero.
    generate
        if (LSB == 0) begin : g_unit
            assign h_aligned = h_inc;
        end else begin : g_wide
            assign h_aligned = {h_inc[HW:LSB], {LSB{1'b0}}};
        end
    endgenerate

    always_comb begin
        h_d        = h_q;
        v_d        = v_q;
        frame_wrap = 1'b0;
        if (adv) begin
            if (h_aligned >= {1'b0, htotal}) begin
                h_d = '0;
                if (v_inc >= {1'b0, vtotal}) begin
                    v_d        = '0;
                    frame_wrap = 1'b1;
                end else begin
                    v_d = v_inc[VW-1:0];
                end
            end else begin
                h_d = h_aligned[HW-1:0];
            end
        end
    end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
(
    input  hpos_t   h,
    input  vpos_t   v,
    input  timing_t t,
    output flags_t  f
);

    always_comb begin
        f = decode_flags(h, v, t);
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int unsigned PPC          = 2,
    parameter int unsigned DEF_HTOTAL   = 40,
    parameter int unsigned DEF_HBEND    = 16,
    parameter int unsigned DEF_HS_ON    = 4,
    parameter int unsigned DEF_HS_OFF   = 8,
    parameter int unsigned DEF_VS_HON   = 4,
    parameter int unsigned DEF_VS_HOFF  = 4,
    parameter int unsigned DEF_VTOTAL   = 12,
    parameter int unsigned DEF_VBEND    = 6,
    parameter int unsigned DEF_VS_VON   = 2,
    parameter int unsigned DEF_VS_VOFF  = 4,
    parameter int unsigned DEF_POL      = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_en,
    input  logic          cfg_load,
    input  logic [HW-1:0] cfg_htotal,
    input  logic [HW-1:0] cfg_hblank_end,
    input  logic [HW-1:0] cfg_hsync_on,
    input  logic [HW-1:0] cfg_hsync_off,
    input  logic [HW-1:0] cfg_vsync_hon,
    input  logic [HW-1:0] cfg_vsync_hoff,
    input  logic [VW-1:0] cfg_vtotal,
    input  logic [VW-1:0] cfg_vblank_end,
    input  logic [VW-1:0] cfg_vsync_on,
    input  logic [VW-1:0] cfg_vsync_off,
    input  logic [3:0]    cfg_polarity,
    output logic          hblank_o,
    output logic          hsync_o,
    output logic          vblank_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [HW-1:0] pix_x_o,
    output logic [VW-1:0] line_y_o
);

    typedef struct packed {
        hpos_t   h;
        vpos_t   v;
        timing_t act;
        timing_t pend;
        flags_t  flg;
    } state_t;

    localparam timing_t DEF_CFG = '{
        htotal:  HW'(DEF_HTOTAL),
        hbend:   HW'(DEF_HBEND),
        hs_on:   HW'(DEF_HS_ON),
        hs_off:  HW'(DEF_HS_OFF),
        vs_hon:  HW'(DEF_VS_HON),
        vs_hoff: HW'(DEF_VS_HOFF),
        vtotal:  VW'(DEF_VTOTAL),
        vbend:   VW'(DEF_VBEND),
        vs_von:  VW'(DEF_VS_VON),
        vs_voff: VW'(DEF_VS_VOFF),
        pol:     4'(DEF_POL)
    };

    localparam flags_t RST_FLG = decode_flags('0, '0, DEF_CFG);

    localparam state_t RST_STATE = '{
        h:    '0,
        v:    '0,
        act:  DEF_CFG,
        pend: DEF_CFG,
        flg:  RST_FLG
    };

    state_t  state_q;
    state_t  state_d;
    hpos_t   h_nx;
    vpos_t   v_nx;
    logic    wrap_nx;
    timing_t act_nx;
    flags_t  flg_nx;
    timing_t cfg_in;
    hpos_t   cur_htotal;
    logic [3:0] cur_pol;

    raster_step #(
        .PPC(PPC)
    ) u_step (
        .h_q        (state_q.h),
        .v_q        (state_q.v),
        .htotal     (state_q.act.htotal),
        .vtotal     (state_q.act.vtotal),
        .adv        (adv_en),
        .h_d        (h_nx),
        .v_d        (v_nx),
        .frame_wrap (wrap_nx)
    );

    // The pending set is adopted only when the raster returns to (0,0).
    always_comb begin
        act_nx = wrap_nx ? state_q.pend : state_q.act;
    end

    raster_decode u_dec (
        .h (h_nx),
        .v (v_nx),
        .t (act_nx),
        .f (flg_nx)
    );

    always_comb begin
        cfg_in = '{
            htotal:  cfg_htotal,
            hbend:   cfg_hblank_end,
            hs_on:   cfg_hsync_on,
            hs_off:  cfg_hsync_off,
            vs_hon:  cfg_vsync_hon,
            vs_hoff: cfg_vsync_hoff,
            vtotal:  cfg_vtotal,
            vbend:   cfg_vblank_end,
            vs_von:  cfg_vsync_on,
            vs_voff: cfg_vsync_off,
            pol:     cfg_polarity
        };
    end

    always_comb begin
        state_d     = state_q;
        state_d.h   = h_nx;
        state_d.v   = v_nx;
        state_d.act = act_nx;
        state_d.flg = flg_nx;
        if (cfg_load) begin
            state_d.pend = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign hblank_o   = state_q.flg.hblank;
    assign hsync_o    = state_q.flg.hsync;
    assign vblank_o   = state_q.flg.vblank;
    assign vsync_o    = state_q.flg.vsync;
    assign de_o       = state_q.flg.de;
    assign pix_x_o    = state_q.h;
    assign line_y_o   = state_q.v;
    assign cur_htotal = state_q.act.htotal;
    assign cur_pol    = state_q.act.pol;

endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker
    import raster_pkg::*;
#(
    parameter int unsigned PPC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adv_en,
    input hpos_t      pix_x,
    input vpos_t      line_y,
    input hpos_t      htotal,
    input logic       de,
    input logic       hblank,
    input logic       vblank,
    input logic [3:0] pol
);

    assert_h_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && (({1'b0, pix_x} + (HW+1)'(PPC)) < {1'b0, htotal}))
        |=> (pix_x == $past(pix_x) + HW'(PPC)));

    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && (({1'b0, pix_x} + (HW+1)'(PPC)) >= {1'b0, htotal}))
        |=> (pix_x == '0));

    assert_line_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_y != $past(line_y)) |-> (pix_x == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> ($stable(pix_x) && $stable(line_y) && $stable(de)));

    assert_de_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((hblank == pol[POL_HB]) && (vblank == pol[POL_VB])));

    assert_cfg_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((pix_x == '0) && (line_y == '0)) |-> $stable(htotal));

endmodule

bind raster_timing_gen raster_timing_checker #(
    .PPC(PPC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (adv_en),
    .pix_x  (pix_x_o),
    .line_y (line_y_o),
    .htotal (cur_htotal),
    .de     (de_o),
    .hblank (hblank_o),
    .vblank (vblank_o),
    .pol    (cur_pol)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
    import raster_pkg::*;

    localparam int PPC = 2;

    typedef struct {
        int ht, hbe, hson, hsoff, vshon, vshoff, vt, vbe, vson, vsoff, pol;
    } tcfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_en = 1'b0;
    logic cfg_load = 1'b0;
    logic hblank_o, hsync_o, vblank_o, vsync_o, de_o;
    logic [HW-1:0] pix_x_o;
    logic [VW-1:0] line_y_o;

    tcfg_t drv;
    tcfg_t m_act;
    tcfg_t m_pend;
    int    mh = 0;
    int    mv = 0;
    bit    m_swapped = 1'b0;
    bit    m_held = 1'b0;
    bit    m_reset = 1'b0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    int    checks = 0;
    int    failures = 0;

    always #5 clk = ~clk;

    function automatic tcfg_t def_cfg();
        tcfg_t c;
        c = '{40, 16, 4, 8, 4, 4, 12, 6, 2, 4, 0};
        return c;
    endfunction

    initial begin
        drv = def_cfg();
    end

    raster_timing_gen uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv_en         (adv_en),
        .cfg_load       (cfg_load),
        .cfg_htotal     (HW'(drv.ht)),
        .cfg_hblank_end (HW'(drv.hbe)),
        .cfg_hsync_on   (HW'(drv.hson)),
        .cfg_hsync_off  (HW'(drv.hsoff)),
        .cfg_vsync_hon  (HW'(drv.vshon)),
        .cfg_vsync_hoff (HW'(drv.vshoff)),
        .cfg_vtotal     (VW'(drv.vt)),
        .cfg_vblank_end (VW'(drv.vbe)),
        .cfg_vsync_on   (VW'(drv.vson)),
        .cfg_vsync_off  (VW'(drv.vsoff)),
        .cfg_polarity   (4'(drv.pol)),
        .hblank_o       (hblank_o),
        .hsync_o        (hsync_o),
        .vblank_o       (vblank_o),
        .vsync_o        (vsync_o),
        .de_o           (de_o),
        .pix_x_o        (pix_x_o),
        .line_y_o       (line_y_o)
    );

    // Behavioural reference, advanced at each rising edge.
    always @(posedge clk) begin
        tcfg_t old_pend;
        started   = 1'b1;
        m_swapped = 1'b0;
        m_held    = 1'b0;
        m_reset   = 1'b0;
        if (!rst_n) begin
            mh      = 0;
            mv      = 0;
            m_act   = def_cfg();
            m_pend  = def_cfg();
            m_reset = 1'b1;
        end else begin
            old_pend = m_pend;
            if (cfg_load) m_pend = drv;
            if (adv_en) begin
                mh = mh + PPC;
                if (mh >= m_act.ht) begin
                    mh = 0;
                    mv = mv + 1;
                    if (mv >= m_act.vt) begin
                        mv        = 0;
                        m_act     = old_pend;
                        m_swapped = 1'b1;
                    end
                end
            end else begin
                m_held = 1'b1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)",
                     req, actual, expected, mh, mv);
        end
    endtask

    // Compare at the falling edge, half a period after the outputs settle.
    always @(negedge clk) begin
        bit hb, hs, vb, vs;
        int pos, von, voff;
        if (started && !done) begin
            hb   = (mh < m_act.hbe);
            hs   = (mh >= m_act.hson) && (mh < m_act.hsoff);
            vb   = (mv < m_act.vbe);
            pos  = mv * 65536 + mh;
            von  = m_act.vson * 65536 + m_act.vshon;
            voff = m_act.vsoff * 65536 + m_act.vshoff;
            vs   = (pos >= von) && (pos < voff);
            if (m_reset) begin
                chk("R9", 32'(pix_x_o), 0);
                chk("R9", 32'(line_y_o), 0);
            end
            chk("R2", 32'(pix_x_o), 32'(mh));
            chk("R2", 32'(line_y_o), 32'(mv));
            chk("R4_R6", 32'(hblank_o), 32'(hb ^ m_act.pol[0]));
            chk("R5_R6", 32'(hsync_o), 32'(hs ^ m_act.pol[1]));
            chk("R1_R6", 32'(vblank_o), 32'(vb ^ m_act.pol[2]));
            chk("R3_R6", 32'(vsync_o), 32'(vs ^ m_act.pol[3]));
            chk("R7", 32'(de_o), 32'(!hb && !vb));
            if (m_swapped) begin
                // R8: a new timing set only appears at the frame origin.
                chk("R8", 32'({line_y_o, pix_x_o}), 0);
            end
            if (m_held) begin
                // R10: a stalled clock must leave the position unchanged.
                chk("R10", 32'(pix_x_o), 32'(mh));
            end
        end
    end

    task automatic run(int n, int en_pct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            adv_en = (($urandom % 100) < en_pct);
        end
    endtask

    task automatic load(tcfg_t c);
        @(negedge clk);
        drv      = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        tcfg_t c2, c3, c4;
        c2 = '{48, 20, 6, 12, 6, 6, 10, 4, 1, 3, 10};
        c3 = '{32, 8, 2, 6, 2, 10, 8, 3, 0, 2, 5};
        c4 = '{36, 10, 2, 4, 8, 2, 9, 2, 0, 1, 15};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(300, 100);
        run(300, 70);
        load(c2);
        run(250, 100);
        run(400, 60);
        // Load while stalled: nothing visible may change (R10).
        adv_en = 1'b0;
        load(c3);
        run(20, 0);
        load(c4);
        load(c3);
        run(700, 85);
        load(c4);
        run(600, 100);
        @(negedge clk);
        rst_n = 1'b0;
        run(3, 100);
        rst_n = 1'b1;
        run(300, 90);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule